// File: doc/BRIEF.md
# Strip-Mining Vector Length Controller

This block breaks a loop of `n` element operations, where `n` may be far larger than a vector register holds, into a series of vector strips. For each strip it presents two values. The first is the index of the strip's first element. The second is the element count to be written into the vector-length register, which tells the datapath how many entries of each vector register the operation uses. The strip that carries the leftover `n mod MVL` elements is issued first. Every strip after it is a full `MVL` elements long.

A sequencer pulses `start` with the loop count on `n_total`. It then consumes strips with a valid/ready handshake. Each strip stays on the outputs until it is accepted. After the strip that ends at element `n-1` is accepted, `done` pulses for one cycle. Address scaling and the vector datapath are outside this block. `MVL` is a parameter with a default of 64 and must be a power of two, at least 2.

Top module: `smvl_strip_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, `strip_valid` and `done` are 0 and `strip_low` is 0.
- R2: When `start` is accepted with `n_total` not 0 and `n_total mod MVL` not 0, the first strip appears in the next cycle with `strip_low` = 0 and `strip_vl` = `n_total mod MVL`.
- R3: When `n_total mod MVL` is 0 and `n_total` is not 0, no empty strip is issued. The first strip has `strip_low` = 0 and `strip_vl` = `MVL`.
- R4: Every strip after the first has `strip_vl` = `MVL`. Its `strip_low` equals the previous strip's `strip_low` plus the previous strip's `strip_vl`.
- R5: While `strip_valid` is 1 and `strip_ready` is 0, `strip_valid`, `strip_low` and `strip_vl` hold their values into the next cycle.
- R6: `done` is 1 for exactly one cycle. That cycle directly follows acceptance of the strip whose `strip_low + strip_vl` equals `n`. `strip_valid` is 0 while `done` is 1.
- R7: When `start` is accepted with `n_total` = 0, `done` is 1 in the next cycle and no strip is issued.
- R8: `start` is accepted only while `strip_valid` is 0. A `start` pulse during a run has no effect on the strips issued.
- R9: The loop count is captured when `start` is accepted. Later changes on `n_total` do not alter the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a new loop (one-cycle pulse) |
| n_total | input | N_W | Total element count of the loop |
| strip_ready | input | 1 | Consumer accepts the presented strip |
| strip_valid | output | 1 | A strip is presented |
| strip_low | output | N_W | Index of the strip's first element |
| strip_vl | output | VL_W | Element count of the strip, 1 to MVL |
| done | output | 1 | One-cycle pulse: the whole loop has been issued |

## Verification
Three kinds of internal error show up quickly at the ports. A corrupted cursor gives a `strip_low` that does not match the running sum of earlier lengths, and this is visible on the very next strip. A wrong first-length computation shows on the first strip, one cycle after `start`. A bad end-of-loop test makes the run stop early or overrun `n`. That appears as a missing or extra strip, or a `done` pulse in the wrong cycle. The bench sweeps every `n` a small configuration allows and applies irregular stall patterns, so each of these errors reaches a checked port value within one strip.

// File: rtl/smvl_pkg.sv
// Shared types for the strip-mining controller.
// Assumes: nothing beyond IEEE 1800-2017.
package smvl_pkg;

    // Sequencer states: waiting, presenting strips, end-of-loop pulse
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FIN   = 2'd2
    } smvl_state_t;

endpackage

// File: rtl/smvl_first_len.sv
// Computes the length of the opening strip for a loop count:
// the remainder modulo MVL, or a full MVL when the remainder is 0.
// Also flags an empty loop.
// Assumes: MVL is a power of two and at least 2, so the remainder
// is simply the low address bits of the count.
module smvl_first_len #(
    parameter int N_W  = 16,
    parameter int MVL  = 64,
    localparam int LOG  = $clog2(MVL),
    localparam int VL_W = $clog2(MVL + 1)
) (
    input  logic [N_W-1:0]  n_in,
    output logic [VL_W-1:0] first_vl,
    output logic            n_zero
);

    logic [LOG-1:0] rem;

    // Pick the remainder, or a full strip when nothing is left over
    always_comb begin
        rem      = n_in[LOG-1:0];
        n_zero   = (n_in == '0);
        if (rem == '0)
            first_vl = VL_W'(MVL);
        else
            first_vl = {{(VL_W-LOG){1'b0}}, rem};
    end

endmodule

// File: rtl/smvl_cursor.sv
// Holds the captured loop count and the current strip (low index and
// length). Advances the strip on request and reports when the current
// strip reaches the end of the loop.
// Assumes: load and advance are never asserted together.
module smvl_cursor #(
    parameter int N_W  = 16,
    parameter int MVL  = 64,
    localparam int VL_W = $clog2(MVL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            advance,
    input  logic [N_W-1:0]  n_in,
    input  logic [VL_W-1:0] first_vl,
    output logic [N_W-1:0]  low,
    output logic [VL_W-1:0] vl,
    output logic            last
);

    logic [N_W-1:0] n_q;
    logic [N_W:0]   strip_end;

    // Capture the count on load, step the strip on advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q <= '0;
            low <= '0;
            vl  <= '0;
        end else if (load) begin
            n_q <= n_in;
            low <= '0;
            vl  <= first_vl;
        end else if (advance) begin
            low <= low + N_W'(vl);
            vl  <= VL_W'(MVL);
        end
    end

    // The current strip is final when it ends exactly at the loop count
    always_comb begin
        strip_end = {1'b0, low} + (N_W+1)'(vl);
        last      = (strip_end == {1'b0, n_q});
    end

endmodule

// File: rtl/smvl_fsm.sv
// Sequencer: accepts start only when no strip is presented, presents
// strips until the final one is accepted, then pulses done once.
// Assumes: the cursor reports last for the strip currently shown.
module smvl_fsm
    import smvl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic n_zero,
    input  logic strip_ready,
    input  logic last,
    output logic load,
    output logic advance,
    output logic strip_valid,
    output logic done
);

    smvl_state_t state_q, state_d;
    logic        accept;

    // Decode handshake events and the next state
    always_comb begin
        accept  = (state_q == ST_ISSUE) && strip_ready;
        load    = start && (state_q != ST_ISSUE);
        advance = accept && !last;
        state_d = state_q;
        case (state_q)
            ST_IDLE, ST_FIN: begin
                if (load)
                    state_d = n_zero ? ST_FIN : ST_ISSUE;
                else
                    state_d = ST_IDLE;
            end
            ST_ISSUE: begin
                if (accept && last)
                    state_d = ST_FIN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Outputs come straight from the state register
    always_comb begin
        strip_valid = (state_q == ST_ISSUE);
        done        = (state_q == ST_FIN);
    end

endmodule

// File: rtl/smvl_strip_ctrl.sv
// Top level of the strip-mining controller. Splits a loop of n_total
// elements into a remainder strip followed by full MVL strips and
// presents each strip under a valid/ready handshake.
// Assumes: MVL is a power of two, at least 2; N_W is wide enough for n.
module smvl_strip_ctrl #(
    parameter int N_W  = 16,
    parameter int MVL  = 64,
    localparam int VL_W = $clog2(MVL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [N_W-1:0]  n_total,
    input  logic            strip_ready,
    output logic            strip_valid,
    output logic [N_W-1:0]  strip_low,
    output logic [VL_W-1:0] strip_vl,
    output logic            done
);

    logic [VL_W-1:0] first_vl;
    logic            n_zero;
    logic            load;
    logic            advance;
    logic            last;

    smvl_first_len #(.N_W(N_W), .MVL(MVL)) u_first (
        .n_in     (n_total),
        .first_vl (first_vl),
        .n_zero   (n_zero)
    );

    smvl_cursor #(.N_W(N_W), .MVL(MVL)) u_cursor (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .advance  (advance),
        .n_in     (n_total),
        .first_vl (first_vl),
        .low      (strip_low),
        .vl       (strip_vl),
        .last     (last)
    );

    smvl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .n_zero      (n_zero),
        .strip_ready (strip_ready),
        .last        (last),
        .load        (load),
        .advance     (advance),
        .strip_valid (strip_valid),
        .done        (done)
    );

endmodule

// File: rtl/smvl_strip_ctrl_chk.sv
// Port-level protocol checker for smvl_strip_ctrl, bound to every instance.
module smvl_strip_ctrl_chk #(
    parameter int N_W  = 16,
    parameter int MVL  = 64,
    localparam int VL_W = $clog2(MVL + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [N_W-1:0]  n_total,
    input logic            strip_ready,
    input logic            strip_valid,
    input logic [N_W-1:0]  strip_low,
    input logic [VL_W-1:0] strip_vl,
    input logic            done
);

    // R5: a stalled strip holds
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        strip_valid && !strip_ready |=>
            strip_valid && $stable(strip_low) && $stable(strip_vl));

    // R4: a following strip continues where the accepted one ended
    a_r4_next_strip: assert property (@(posedge clk) disable iff (!rst_n)
        strip_valid && strip_ready |=>
            !strip_valid ||
            (strip_low == $past(strip_low) + N_W'($past(strip_vl)) &&
             strip_vl == VL_W'(MVL)));

    // R2, R3: a presented strip is never empty nor longer than MVL
    a_r3_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        strip_valid |-> (strip_vl != '0) && (strip_vl <= VL_W'(MVL)));

    // R6: done is a single-cycle pulse and excludes strip_valid
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && strip_valid));

    // R2: a nonempty loop opens at element 0
    a_r2_first_low: assert property (@(posedge clk) disable iff (!rst_n)
        start && !strip_valid && (n_total != '0) |=>
            strip_valid && (strip_low == '0));

    // R7: an empty loop finishes at once
    a_r7_empty_loop: assert property (@(posedge clk) disable iff (!rst_n)
        start && !strip_valid && (n_total == '0) |=> done && !strip_valid);

endmodule

bind smvl_strip_ctrl smvl_strip_ctrl_chk #(.N_W(N_W), .MVL(MVL)) u_chk (.*);

// File: tb/smvl_strip_ctrl_test.sv
// Exhaustive sweep of the loop count on a small configuration with
// irregular consumer stalls; expected strips computed arithmetically.
module smvl_strip_ctrl_test;

    localparam int N_W  = 8;
    localparam int MVL  = 8;
    localparam int VL_W = $clog2(MVL + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [N_W-1:0]  n_total = '0;
    logic            strip_ready = 1'b0;
    logic            strip_valid;
    logic [N_W-1:0]  strip_low;
    logic [VL_W-1:0] strip_vl;
    logic            done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] lfsr = 8'hA5;

    always #10 clk = ~clk;

    smvl_strip_ctrl #(.N_W(N_W), .MVL(MVL)) uut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    function automatic bit next_stall();
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        return lfsr[0] & lfsr[2];
    endfunction

    task automatic run_loop(input int n, input bit poke_start);
        int exp_low;
        int exp_vl;
        int strips;
        @(negedge clk);
        start = 1'b1;
        n_total = N_W'(n);
        @(negedge clk);
        start = 1'b0;
        n_total = N_W'(n ^ 8'h5A);  // R9: count changes after capture
        if (n == 0) begin
            check(done == 1'b1, "R7", int'(done), 1);
            check(strip_valid == 1'b0, "R7", int'(strip_valid), 0);
            @(negedge clk);
            check(done == 1'b0, "R6", int'(done), 0);
            return;
        end
        exp_low = 0;
        exp_vl = (n % MVL == 0) ? MVL : n % MVL;
        strips = 0;
        while (exp_low < n) begin
            check(strip_valid == 1'b1, "R9", int'(strip_valid), 1);
            check(done == 1'b0, "R6", int'(done), 0);
            check(int'(strip_low) == exp_low, strips == 0 ? "R2" : "R4", int'(strip_low), exp_low);
            check(int'(strip_vl) == exp_vl,
                  strips == 0 ? ((n % MVL == 0) ? "R3" : "R2") : "R4", int'(strip_vl), exp_vl);
            if (next_stall()) begin
                strip_ready = 1'b0;
                if (poke_start) begin
                    start = 1'b1;  // R8: ignored while a strip is shown
                    n_total = 8'd3;
                end
                @(negedge clk);
                start = 1'b0;
                check(strip_valid == 1'b1 && int'(strip_low) == exp_low &&
                      int'(strip_vl) == exp_vl, poke_start ? "R8" : "R5",
                      int'(strip_low), exp_low);
            end
            strip_ready = 1'b1;
            @(negedge clk);
            strip_ready = 1'b0;
            exp_low += exp_vl;
            exp_vl = MVL;
            strips++;
        end
        check(done == 1'b1, "R6", int'(done), 1);
        check(strip_valid == 1'b0, "R6", int'(strip_valid), 0);
        @(negedge clk);
        check(done == 1'b0, "R6", int'(done), 0);
        check(strip_valid == 1'b0, "R6", int'(strip_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(strip_valid == 1'b0, "R1", int'(strip_valid), 0);
        check(done == 1'b0, "R1", int'(done), 0);
        check(strip_low == '0, "R1", int'(strip_low), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(strip_valid == 1'b0 && done == 1'b0, "R1", int'(strip_valid), 0);
        for (int n = 0; n < (1 << N_W); n++)
            run_loop(n, (n % 3) == 1);
        // Boundary counts once more, back to back with stalls and pokes
        run_loop(MVL, 1'b1);
        run_loop(MVL + 1, 1'b1);
        run_loop((1 << N_W) - 1, 1'b1);
        run_loop(0, 1'b0);
        finish_run();
    end

endmodule